// File: doc/BRIEF.md
# Interrupt Event Status and Enable Bank

This block collects single-cycle event pulses from a storage-card host controller's command path, data path and card-interrupt logic into one 32-bit status register. Software clears a status bit by writing a one to it. Two mask registers use the same bit layout as the status register. The latch mask decides which events are recorded at all. The line mask decides which recorded events drive the single level interrupt output. A summary bit at position 15 shows whether any error event in the upper half is pending.

Software reaches the three registers through a small select/write/read port. A select value of 0 picks the status register, 1 the latch mask and 2 the line mask. Select 3 is a hole. Reads are combinational from the selected register. Writes take effect at the next rising clock edge. The asynchronous active-low reset is released synchronously through two flops before the bank leaves reset.

Implemented event bits:
- Normal events: 0, 1, 2, 4 and 5, plus the card interrupt at 8.
- Error events: 16 to 22, 24, 28 and 29.

Top module: `evt_irq_bank`

## Requirements
- R1: After reset the status register, both masks and `irq_o` read 0.
- R2: A pulse on `evt_pulse[i]` for an implemented event bit other than 8 sets status bit i at the next edge only if latch-mask bit i is 1. Otherwise status stays unchanged.
- R3: A status write (select 0) clears each implemented event bit written as 1 and leaves bits written as 0 unchanged.
- R4: When an enabled event pulse and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R5: Status bit 15 reads 1 exactly when any status bit in 31:16 is 1. Writes to bit 15 are ignored, and it clears only when the error bits are cleared.
- R6: `irq_o` is 1 exactly when some bit of the status read value, including bit 15, is 1 with its line-mask bit also 1. Masking the line does not discard the latched status.
- R7: Status bit 8 takes the value of `card_lvl` AND latch-mask bit 8 one cycle later. Writes to bit 8 and `evt_pulse[8]` have no effect on it.
- R8: Bits 3, 6, 7, 9–14, 23, 25–27, 30 and 31 read 0 in all three registers, whatever is written or pulsed. Mask bit 15 is writable.
- R9: Select codes are 0 = status, 1 = latch mask, 2 = line mask. Select 3 reads 0, and writes to it change no register.
- R10: Clearing a latch-mask bit keeps an already latched status bit set but blocks later pulses on that bit.
- R11: Writing all ones to the status register clears every event bit and the summary bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 32 | Single-cycle event pulses, one per status bit |
| card_lvl | input | 1 | Card interrupt level |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 status, 1 latch mask, 2 line mask) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Level interrupt output |

## Verification
Single normal events, single error events and multi-bit pulse groups are applied with the latch mask both open and closed. This separates gating from plain latching. Clearing writes use partial patterns, zero patterns and all-ones patterns, and one clearing write coincides with a pulse on the same bit. This shows selective clearing apart from event priority. Error pulses with only mask bit 15 enabled show whether the summary bit, and not a raw error bit, drives the line. Pulses and writes aimed at unimplemented bits, at the card bit and at select 3 confirm that those paths leave observable state untouched.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned CARD_BIT  = 8;
  localparam int unsigned SUM_BIT   = 15;
  localparam int unsigned ERR_LO    = 16;
  // implemented event bits, card level included, summary excluded
  localparam logic [DW-1:0] EVT_MASK  = 32'h317F_0137;
  localparam logic [DW-1:0] VALID_MSK = EVT_MASK | (32'd1 << SUM_BIT);

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_LATCHEN = 2'd1,
    SEL_LINEEN  = 2'd2,
    SEL_HOLE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int unsigned     W    = 32,
  parameter logic [W-1:0]    KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;

  always_comb mask_d = wdata & KEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '0;
    else if (we) mask_q <= mask_d;
  end

  assign q = mask_q;
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned  W        = 32,
  parameter logic [W-1:0] EVT_MASK = '0,
  parameter int unsigned  CARD_BIT = 8,
  parameter int unsigned  SUM_BIT  = 15,
  parameter int unsigned  ERR_LO   = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         card_lvl,
  input  logic [W-1:0] latch_en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat_raw,
  output logic [W-1:0] stat_view
);
  localparam logic [W-1:0] PULSE_MSK = EVT_MASK & ~(W'(1) << CARD_BIT);
  localparam logic [W-1:0] SUM_ONE   = W'(1) << SUM_BIT;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == CARD_BIT) begin : g_card
      logic lvl_q;
      logic lvl_d;
      always_comb lvl_d = card_lvl & latch_en[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
      end
      assign stat_raw[i] = lvl_q;
    end else if (PULSE_MSK[i]) begin : g_evt
      logic ev_q;
      logic ev_d;
      logic ev_upd;
      always_comb begin
        ev_upd = clr[i] | evt[i];
        ev_d   = (ev_q & ~clr[i]) | (evt[i] & latch_en[i]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ev_q <= 1'b0;
        else if (ev_upd) ev_q <= ev_d;
      end
      assign stat_raw[i] = ev_q;
    end else begin : g_none
      assign stat_raw[i] = 1'b0;
    end
  end

  logic err_any;
  always_comb begin
    err_any   = |stat_raw[W-1:ERR_LO];
    stat_view = stat_raw | (err_any ? SUM_ONE : '0);
  end

  logic unused_bits;
  assign unused_bits = ^{evt & ~PULSE_MSK, clr & ~PULSE_MSK, latch_en & ~EVT_MASK};
endmodule

// File: rtl/evt_irq_combine.sv
module evt_irq_combine #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] stat_view,
  input  logic [W-1:0] line_en,
  output logic         irq
);
  logic [W-1:0] hit;
  always_comb begin
    hit = stat_view & line_en;
    irq = |hit;
  end
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank
  import evt_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_pulse,
  input  logic          card_lvl,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);
  logic          rst_q_n;
  logic          we_stat, we_latch, we_line;
  logic [DW-1:0] clr_bits;
  logic [DW-1:0] latch_en_q, line_en_q;
  logic [DW-1:0] stat_raw, stat_view;

  evt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  always_comb begin
    we_stat  = reg_wr && (reg_sel == SEL_STATUS);
    we_latch = reg_wr && (reg_sel == SEL_LATCHEN);
    we_line  = reg_wr && (reg_sel == SEL_LINEEN);
    clr_bits = we_stat ? reg_wdata : '0;
  end

  evt_mask_reg #(.W(DW), .KEEP(VALID_MSK)) u_latch_en (
    .clk(clk), .rst_n(rst_q_n), .we(we_latch), .wdata(reg_wdata), .q(latch_en_q)
  );

  evt_mask_reg #(.W(DW), .KEEP(VALID_MSK)) u_line_en (
    .clk(clk), .rst_n(rst_q_n), .we(we_line), .wdata(reg_wdata), .q(line_en_q)
  );

  evt_status_bank #(
    .W(DW), .EVT_MASK(EVT_MASK), .CARD_BIT(CARD_BIT),
    .SUM_BIT(SUM_BIT), .ERR_LO(ERR_LO)
  ) u_status (
    .clk(clk), .rst_n(rst_q_n), .evt(evt_pulse), .card_lvl(card_lvl),
    .latch_en(latch_en_q), .clr(clr_bits),
    .stat_raw(stat_raw), .stat_view(stat_view)
  );

  evt_irq_combine #(.W(DW)) u_irq (
    .stat_view(stat_view), .line_en(line_en_q), .irq(irq_o)
  );

  always_comb begin
    unique case (reg_sel)
      SEL_STATUS:  reg_rdata = stat_view;
      SEL_LATCHEN: reg_rdata = latch_en_q;
      SEL_LINEEN:  reg_rdata = line_en_q;
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_bank_chk.sv
module evt_irq_bank_chk
  import evt_irq_pkg::*;
(
  input logic          clk,
  input logic          rst_q_n,
  input logic [DW-1:0] evt_pulse,
  input logic          card_lvl,
  input logic [1:0]    reg_sel,
  input logic [DW-1:0] stat_raw,
  input logic [DW-1:0] latch_en_q,
  input logic [DW-1:0] line_en_q,
  input logic [DW-1:0] reg_rdata,
  input logic          irq_o
);
  localparam logic [DW-1:0] PULSE = EVT_MASK & ~(32'd1 << CARD_BIT);

  // R2: no pulse bit rises without its latch-mask bit
  a_r2_gated_latch: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((stat_raw & ~$past(stat_raw) & ~$past(latch_en_q) & PULSE) == '0));

  // R4: an enabled pulse always leaves its bit set
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((evt_pulse & latch_en_q & PULSE) != '0) |=>
      (($past(evt_pulse & latch_en_q) & PULSE & ~stat_raw) == '0));

  // R5: summary bit on the status read path
  a_r5_summary: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_sel == SEL_STATUS) |-> (reg_rdata[SUM_BIT] == (|reg_rdata[DW-1:ERR_LO])));

  // R6: interrupt needs some line-mask bit
  a_r6_line_needs_mask: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_o |-> (line_en_q != '0));

  // R7: card bit follows its level one cycle later
  a_r7_card_level: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> (stat_raw[CARD_BIT] == $past(card_lvl & latch_en_q[CARD_BIT])));

  // R8: unimplemented bits never read 1
  a_r8_holes_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((reg_rdata & ~VALID_MSK) == '0));

  // R9: select 3 reads zero
  a_r9_hole_sel: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_sel == SEL_HOLE) |-> (reg_rdata == '0));
endmodule

bind evt_irq_bank evt_irq_bank_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .evt_pulse(evt_pulse), .card_lvl(card_lvl),
  .reg_sel(reg_sel), .stat_raw(stat_raw), .latch_en_q(latch_en_q),
  .line_en_q(line_en_q), .reg_rdata(reg_rdata), .irq_o(irq_o)
);

// File: tb/evt_irq_bank_test.sv
module evt_irq_bank_test;
  localparam logic [31:0] VALID = 32'h317F_8137;

  logic        clk;
  logic        rst_n;
  logic [31:0] evt_pulse;
  logic        card_lvl;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  evt_irq_bank uut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .card_lvl(card_lvl),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(logic [1:0] sel, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(logic [31:0] e);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [31:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic prep(logic [31:0] len, logic [31:0] lin);
    card_lvl = 1'b0;
    wr(2'd1, len);
    wr(2'd2, lin);
    @(negedge clk);
    wr(2'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); check("R1 status", v, 32'h0);
    rd(2'd1, v); check("R1 latch", v, 32'h0);
    rd(2'd2, v); check("R1 line", v, 32'h0);
    check("R1 irq", {31'd0, irq_o}, 32'h0);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    pulse(32'h0000_0001);
    rd(2'd0, v); check("R2 closed", v, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R8 latch holes", v, VALID);
    pulse(32'h0000_0031);
    rd(2'd0, v); check("R2 open", v, 32'h0000_0031);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    prep(32'h0000_0037, 32'h0);
    pulse(32'h0000_0037);
    wr(2'd0, 32'h0000_0005);
    rd(2'd0, v); check("R3 partial", v, 32'h0000_0032);
    wr(2'd0, 32'h0);
    rd(2'd0, v); check("R3 zero", v, 32'h0000_0032);
  endtask

  task automatic t_race;
    logic [31:0] v;
    prep(32'h0000_0037, 32'h0);
    pulse(32'h0000_0010);
    evt_pulse = 32'h0000_0002;
    wr(2'd0, 32'h0000_0012);
    evt_pulse = '0;
    rd(2'd0, v); check("R4 event wins", v, 32'h0000_0002);
  endtask

  task automatic t_summary;
    logic [31:0] v;
    prep(32'hFFFF_FFFF, 32'h0);
    pulse(32'h0010_0000);
    rd(2'd0, v); check("R5 set", v, 32'h0010_8000);
    wr(2'd0, 32'h0000_8000);
    rd(2'd0, v); check("R5 write ignored", v, 32'h0010_8000);
    wr(2'd0, 32'h0010_0000);
    rd(2'd0, v); check("R5 cleared", v, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    prep(32'hFFFF_FFFF, 32'h0);
    pulse(32'h0000_0020);
    check("R6 masked", {31'd0, irq_o}, 32'h0);
    wr(2'd2, 32'h0000_0020);
    check("R6 raised", {31'd0, irq_o}, 32'h1);
    wr(2'd0, 32'h0000_0020);
    check("R6 dropped", {31'd0, irq_o}, 32'h0);
    wr(2'd2, 32'h0000_8000);
    pulse(32'h0002_0000);
    check("R6 via summary", {31'd0, irq_o}, 32'h1);
    wr(2'd2, 32'h0);
    rd(2'd0, v); check("R6 kept", v, 32'h0002_8000);
  endtask

  task automatic t_card;
    logic [31:0] v;
    prep(32'h0000_0100, 32'h0);
    card_lvl = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R7 follows", v, 32'h0000_0100);
    wr(2'd0, 32'h0000_0100);
    rd(2'd0, v); check("R7 write ignored", v, 32'h0000_0100);
    card_lvl = 1'b0;
    @(negedge clk);
    rd(2'd0, v); check("R7 drops", v, 32'h0);
    pulse(32'h0000_0100);
    rd(2'd0, v); check("R7 pulse ignored", v, 32'h0);
  endtask

  task automatic t_holes;
    logic [31:0] v;
    prep(32'hFFFF_FFFF, 32'h0);
    pulse(32'hCE80_7EC8);
    rd(2'd0, v); check("R8 status holes", v, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R8 line holes", v, VALID);
  endtask

  task automatic t_sel3;
    logic [31:0] v;
    prep(32'h0000_0001, 32'h0000_0002);
    pulse(32'h0000_0001);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R9 hole read", v, 32'h0);
    rd(2'd0, v); check("R9 status kept", v, 32'h0000_0001);
    rd(2'd1, v); check("R9 latch kept", v, 32'h0000_0001);
    rd(2'd2, v); check("R9 line kept", v, 32'h0000_0002);
  endtask

  task automatic t_mask_drop;
    logic [31:0] v;
    prep(32'h0000_0003, 32'h0);
    pulse(32'h0000_0001);
    wr(2'd1, 32'h0);
    rd(2'd0, v); check("R10 kept", v, 32'h0000_0001);
    pulse(32'h0000_0002);
    rd(2'd0, v); check("R10 blocked", v, 32'h0000_0001);
  endtask

  task automatic t_clear_all;
    logic [31:0] v;
    prep(32'hFFFF_FFFF, 32'h0);
    pulse(32'h317F_0037);
    rd(2'd0, v); check("R11 full", v, 32'h317F_8037);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R11 cleared", v, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_pulse = '0; card_lvl = 1'b0;
    reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_gate;
    t_w1c;
    t_race;
    t_summary;
    t_irq;
    t_card;
    t_holes;
    t_sel3;
    t_mask_drop;
    t_clear_all;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule